// File: doc/BRIEF.md
# Subsystem Event Trigger Node

This block sits at the subsystem end of a star-shaped event network. It has two jobs. First, it watches a set of external digital inputs that run with no relation to its clock. When one of those inputs shows a clean rising edge, the block sends an 8-bit event code for that input toward the hub, one byte at a time, over a valid/ready byte port. Second, it listens to event bytes arriving from the hub. When a byte matches the code programmed for a trigger output, that output waits for its programmed delay and then drives a pulse of its programmed width.

All timing runs on an internal microsecond tick that is divided down from the clock. Delays and widths are counted in whole ticks. Code value 0 never stands for an event. It is never sent, and a received 0 never triggers anything.

Configuration is done with single-cycle register writes. The upper two address bits pick what is written and the lower bits pick the channel. A write to an output is dropped while that output is busy.

Top module: `evt_trigger_node`

## Requirements
- R1: After reset, every trigger output is low and `tx_valid` is low.
- R2: An input rising edge is accepted only after the synchronised input has differed from its filtered level for STABLE_TICKS consecutive microsecond ticks. A shorter high pulse yields no event, and a falling edge never yields an event.
- R3: An accepted edge on an input whose code is non-zero queues that code for sending exactly once. An input whose code is 0 queues nothing. `tx_data` is never 0 while `tx_valid` is high.
- R4: When several codes are queued, `tx_data` presents the lowest-indexed input's code first. A byte leaves the queue only on a cycle where `tx_valid` and `tx_ready` are both high.
- R5: A received byte of value 0 starts no output, even when an output's code is 0.
- R6: When an output with delay D accepts a matching code, the output rises between D*CLK_PER_US+1 and (D+1)*CLK_PER_US clock cycles after the match cycle.
- R7: A pulse of width W stays high for exactly W*CLK_PER_US cycles. It rises and falls on a tick boundary.
- R8: An output whose width is 0 never pulses.
- R9: A matching code that arrives while the output's delay or pulse is running drives the output low on the next cycle and restarts the delay from the new match.
- R10: All outputs that share the received code start in the same cycle, and identically configured ones pulse in lockstep.
- R11: A configuration write to an output whose delay or pulse is running has no effect. A write to an idle output takes effect.
- R12: Write address layout: `cfg_addr[4:3]` selects 0 = input code, 1 = output code, 2 = output delay, 3 = output width. `cfg_addr[2:0]` selects the channel. Codes use `cfg_wdata[7:0]`. A received code pulses only the outputs holding that code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 8 | Asynchronous external event inputs |
| trig_out | output | 8 | Trigger pulse outputs |
| tx_valid | output | 1 | An event byte is offered to the hub link |
| tx_data | output | 8 | Event code being offered |
| tx_ready | input | 1 | Link accepts the offered byte this cycle |
| rx_valid | input | 1 | A byte from the hub is present this cycle |
| rx_data | input | 8 | Received event code |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Field select (bits 4:3) and channel (bits 2:0) |
| cfg_wdata | input | 16 | Write data |

## Verification
The bench sweeps delay and width across all eight outputs and checks the rise against the tick window and the width to the exact cycle. This catches an off-by-one in either countdown, and a wrong address decode would light up the wrong output. It raises three inputs in one tick while the link is stalled and expects the bytes in index order; a design that picks the highest index, or that drops a queued code, shows up there. A glitch of two ticks must produce nothing, and so must a falling edge. A filter that counts from the wrong value, or that reacts to both edges, would send a byte. The bench also retriggers during a pulse, writes a new width during a delay, fires a shared code, and sends width-0 and code-0 cases. A design without restart, without the write lock, or without the zero guards would show a stale pulse, a changed width, skewed outputs or a spurious pulse.

// File: rtl/evt_trigger_node.sv
module evt_trigger_node #(
  parameter int N_IN         = 8,
  parameter int N_OUT        = 8,
  parameter int CODE_W       = 8,
  parameter int TIME_W       = 16,
  parameter int CLK_PER_US   = 100,
  parameter int STABLE_TICKS = 4,
  localparam int IDX_W       = $clog2(N_IN > N_OUT ? N_IN : N_OUT),
  localparam int DATA_W      = TIME_W > CODE_W ? TIME_W : CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   evt_in,
  output logic [N_OUT-1:0]  trig_out,
  output logic              tx_valid,
  output logic [CODE_W-1:0] tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [CODE_W-1:0] rx_data,
  input  logic              cfg_we,
  input  logic [IDX_W+1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata
);

  localparam int DIV_W   = $clog2(CLK_PER_US);
  localparam int STB_W   = $clog2(STABLE_TICKS + 1);
  localparam int SEL_W   = $clog2(N_IN);
  localparam logic [1:0] ST_IDLE  = 2'd0;
  localparam logic [1:0] ST_WAIT  = 2'd1;
  localparam logic [1:0] ST_PULSE = 2'd2;
  localparam logic [1:0] K_INCODE  = 2'd0;
  localparam logic [1:0] K_OUTCODE = 2'd1;
  localparam logic [1:0] K_DELAY   = 2'd2;
  localparam logic [1:0] K_WIDTH   = 2'd3;

  logic [DIV_W-1:0] div_q;
  logic             tick;
  assign tick = (div_q == DIV_W'(CLK_PER_US - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;

  wire [1:0]       cfg_kind = cfg_addr[IDX_W+1:IDX_W];
  wire [IDX_W-1:0] cfg_idx  = cfg_addr[IDX_W-1:0];

  // ---------------- input side ----------------
  logic [N_IN-1:0]   s1_q, s2_q, filt_q, pend_q, accept, clr;
  logic [STB_W-1:0]  stb_q       [N_IN];
  logic [CODE_W-1:0] in_code_q   [N_IN];
  logic [CODE_W-1:0] pend_code_q [N_IN];
  logic [SEL_W-1:0]  sel;

  always_comb
    for (int i = 0; i < N_IN; i++)
      accept[i] = tick && s2_q[i] && !filt_q[i] && (stb_q[i] == STB_W'(STABLE_TICKS - 1));

  always_comb begin
    sel = '0;
    for (int i = N_IN - 1; i >= 0; i--)
      if (pend_q[i]) sel = SEL_W'(i);
  end

  assign tx_valid = |pend_q;
  assign tx_data  = pend_code_q[sel];

  always_comb begin
    clr = '0;
    if (tx_valid && tx_ready) clr[sel] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      filt_q <= '0;
      pend_q <= '0;
      for (int i = 0; i < N_IN; i++) begin
        stb_q[i]       <= '0;
        in_code_q[i]   <= '0;
        pend_code_q[i] <= '0;
      end
    end else begin
      s1_q <= evt_in;
      s2_q <= s1_q;
      for (int i = 0; i < N_IN; i++) begin
        if (s2_q[i] == filt_q[i]) stb_q[i] <= '0;
        else if (tick) begin
          if (stb_q[i] == STB_W'(STABLE_TICKS - 1)) begin
            filt_q[i] <= s2_q[i];
            stb_q[i]  <= '0;
          end else stb_q[i] <= stb_q[i] + 1'b1;
        end
        if (accept[i] && in_code_q[i] != '0) begin
          pend_q[i]      <= 1'b1;
          pend_code_q[i] <= in_code_q[i];
        end else if (clr[i]) pend_q[i] <= 1'b0;
        if (cfg_we && cfg_kind == K_INCODE && cfg_idx == IDX_W'(i))
          in_code_q[i] <= cfg_wdata[CODE_W-1:0];
      end
    end
  end

  assert_tx_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_data != '0);

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && pend_q[0]) |=> (tx_valid && $stable(tx_data)));

  // ---------------- output side ----------------
  logic [1:0]        st_q       [N_OUT];
  logic [TIME_W-1:0] cnt_q      [N_OUT];
  logic [CODE_W-1:0] out_code_q [N_OUT];
  logic [TIME_W-1:0] dly_q      [N_OUT];
  logic [TIME_W-1:0] wid_q      [N_OUT];
  logic [N_OUT-1:0]  hit;

  always_comb
    for (int j = 0; j < N_OUT; j++)
      hit[j] = rx_valid && rx_data != '0 && rx_data == out_code_q[j] && wid_q[j] != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N_OUT; j++) begin
        st_q[j]       <= ST_IDLE;
        cnt_q[j]      <= '0;
        out_code_q[j] <= '0;
        dly_q[j]      <= '0;
        wid_q[j]      <= '0;
      end
    end else begin
      for (int j = 0; j < N_OUT; j++) begin
        if (hit[j]) begin
          st_q[j]  <= ST_WAIT;
          cnt_q[j] <= dly_q[j];
        end else if (tick) begin
          case (st_q[j])
            ST_WAIT:
              if (cnt_q[j] == '0) begin
                st_q[j]  <= ST_PULSE;
                cnt_q[j] <= wid_q[j];
              end else cnt_q[j] <= cnt_q[j] - 1'b1;
            ST_PULSE:
              if (cnt_q[j] <= TIME_W'(1)) st_q[j] <= ST_IDLE;
              else cnt_q[j] <= cnt_q[j] - 1'b1;
            default: ;
          endcase
        end
        if (cfg_we && st_q[j] == ST_IDLE && cfg_idx == IDX_W'(j))
          case (cfg_kind)
            K_OUTCODE: out_code_q[j] <= cfg_wdata[CODE_W-1:0];
            K_DELAY:   dly_q[j]      <= cfg_wdata[TIME_W-1:0];
            K_WIDTH:   wid_q[j]      <= cfg_wdata[TIME_W-1:0];
            default: ;
          endcase
      end
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    assign trig_out[j] = (st_q[j] == ST_PULSE);

    assert_restart_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit[j] |=> !trig_out[j]);

    assert_zero_width_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out[j] |-> wid_q[j] != '0);

    assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[j] != ST_IDLE) |=> ($stable(wid_q[j]) && $stable(dly_q[j]) && $stable(out_code_q[j])));

    assert_edge_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(trig_out[j]) || $fell(trig_out[j])) |-> ($past(tick) || $past(hit[j])));
  end

endmodule

// File: tb/evt_trigger_node_tb_top.sv
module evt_trigger_node_tb_top;
  localparam int P  = 4;
  localparam int ST = 3;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] evt_in = '0;
  logic [7:0] trig_out;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 0;
  logic       rx_valid = 0;
  logic [7:0] rx_data = '0;
  logic       cfg_we = 0;
  logic [4:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] got [64];
  int n_got = 0;

  always #5 clk = ~clk;

  evt_trigger_node #(.CLK_PER_US(P), .STABLE_TICKS(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .trig_out(trig_out),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata));

  always @(posedge clk)
    if (rst_n && tx_valid && tx_ready && n_got < 64) begin
      got[n_got] = tx_data;
      n_got++;
    end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] kind, input int idx, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {kind, 3'(idx)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_rx(input logic [7:0] code);
    @(negedge clk);
    rx_valid = 1; rx_data = code;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic wait_measure(input int idx, output int k, output int w, output bit other);
    k = -1; w = 0; other = 0;
    for (int n = 0; n < 400; n++) begin
      if (trig_out[idx]) begin k = n; break; end
      if ((trig_out & ~(8'b1 << idx)) != 0) other = 1;
      @(negedge clk);
    end
    if (k >= 0)
      while (trig_out[idx] && w < 400) begin w++; @(negedge clk); end
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int k, w, base, hi;
    bit other, skew, fired0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(trig_out == 0, "R1 outputs low", trig_out, 0);
    check(tx_valid == 0, "R1 tx idle", tx_valid, 0);

    for (int i = 0; i < 8; i++) cfg_write(2'd0, i, (i == 6) ? 16'h0 : 16'h10 + 16'(i));

    // R4 ordering with stalled link
    tx_ready = 0;
    @(negedge clk); evt_in = 8'b1010_0100;
    settle((ST + 2) * P + 6);
    check(tx_valid && tx_data == 8'h12, "R4 lowest first offered", tx_data, 8'h12);
    settle(5);
    check(n_got == 0 && tx_data == 8'h12, "R4 held while not ready", n_got, 0);
    base = n_got;
    tx_ready = 1;
    settle(6);
    check(n_got - base == 3, "R4 count", n_got - base, 3);
    check(got[base] == 8'h12, "R4 first", got[base], 8'h12);
    check(got[base+1] == 8'h15, "R4 second", got[base+1], 8'h15);
    check(got[base+2] == 8'h17, "R4 third", got[base+2], 8'h17);
    check(tx_valid == 0, "R3 sent once", tx_valid, 0);

    // R2 falling edges yield nothing
    base = n_got;
    evt_in = 8'h00;
    settle((ST + 3) * P + 6);
    check(n_got == base, "R2 falling edge silent", n_got - base, 0);

    // R2 glitch of two ticks rejected
    @(negedge clk); evt_in[0] = 1;
    settle(2 * P);
    evt_in[0] = 0;
    settle((ST + 3) * P);
    check(n_got == base, "R2 short pulse rejected", n_got - base, 0);

    // R2 long pulse accepted exactly once
    @(negedge clk); evt_in[0] = 1;
    settle((ST + 6) * P);
    check(n_got - base == 1 && got[base] == 8'h10, "R2 stable edge sent", got[base], 8'h10);
    evt_in[0] = 0;
    settle((ST + 3) * P);

    // R3 input with code 0
    base = n_got;
    evt_in[6] = 1;
    settle((ST + 6) * P);
    check(n_got == base, "R3 zero-code input silent", n_got - base, 0);
    evt_in[6] = 0;
    settle((ST + 3) * P);

    // R6 R7 R12 sweep over all outputs
    for (int i = 0; i < 8; i++) begin
      cfg_write(2'd1, i, 16'h40 + 16'(i));
      cfg_write(2'd2, i, 16'(i % 4));
      cfg_write(2'd3, i, 16'((i % 3) + 1));
    end
    for (int i = 0; i < 8; i++) begin
      send_rx(8'h40 + 8'(i));
      wait_measure(i, k, w, other);
      check(k >= (i % 4) * P + 1 && k <= ((i % 4) + 1) * P, "R6 delay window", k, (i % 4) * P + 1);
      check(w == ((i % 3) + 1) * P, "R7 exact width", w, ((i % 3) + 1) * P);
      check(!other, "R12 only own output", other, 0);
    end

    // R8 width 0
    cfg_write(2'd3, 0, 16'd0);
    send_rx(8'h40);
    fired0 = 0;
    for (int n = 0; n < 100; n++) begin if (trig_out != 0) fired0 = 1; @(negedge clk); end
    check(!fired0, "R8 width zero silent", fired0, 0);

    // R5 received zero
    cfg_write(2'd1, 1, 16'h00);
    send_rx(8'h00);
    fired0 = 0;
    for (int n = 0; n < 100; n++) begin if (trig_out != 0) fired0 = 1; @(negedge clk); end
    check(!fired0, "R5 zero code ignored", fired0, 0);

    // R10 shared code
    cfg_write(2'd1, 2, 16'h77); cfg_write(2'd2, 2, 16'd2); cfg_write(2'd3, 2, 16'd2);
    cfg_write(2'd1, 3, 16'h77); cfg_write(2'd2, 3, 16'd2); cfg_write(2'd3, 3, 16'd2);
    send_rx(8'h77);
    skew = 0; hi = 0;
    for (int n = 0; n < 100; n++) begin
      if (trig_out[2] != trig_out[3]) skew = 1;
      if (trig_out[2]) hi++;
      @(negedge clk);
    end
    check(!skew, "R10 lockstep", skew, 0);
    check(hi == 2 * P, "R10 both fired", hi, 2 * P);

    // R9 retrigger during pulse and during delay
    cfg_write(2'd2, 4, 16'd3); cfg_write(2'd3, 4, 16'd4);
    send_rx(8'h44);
    for (int n = 0; n < 100 && !trig_out[4]; n++) @(negedge clk);
    check(trig_out[4], "R9 first pulse", trig_out[4], 1);
    send_rx(8'h44);
    check(!trig_out[4], "R9 low after retrigger", trig_out[4], 0);
    wait_measure(4, k, w, other);
    check(k >= 3 * P + 1 && k <= 4 * P, "R9 delay restarted", k, 3 * P + 1);
    check(w == 4 * P, "R9 width after restart", w, 4 * P);
    send_rx(8'h44);
    settle(2 * P);
    send_rx(8'h44);
    wait_measure(4, k, w, other);
    check(k >= 3 * P + 1 && k <= 4 * P, "R9 restart in delay", k, 3 * P + 1);

    // R11 write lock while busy, accepted when idle
    cfg_write(2'd2, 5, 16'd5); cfg_write(2'd3, 5, 16'd3);
    send_rx(8'h45);
    cfg_write(2'd3, 5, 16'd10);
    wait_measure(5, k, w, other);
    check(w == 3 * P, "R11 busy write dropped", w, 3 * P);
    cfg_write(2'd3, 5, 16'd1);
    send_rx(8'h45);
    wait_measure(5, k, w, other);
    check(w == P, "R11 idle write applied", w, P);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule